// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block supervises software by counting slow ticks in a small overflow counter and raising a system reset pulse when that counter wraps. The ticks come from one of several prescaler taps supplied as input levels; the block detects their rising edges, and for the longest interval it adds a further divide-by-eight stage. Software keeps the system alive by issuing a clear read strobe often enough that the counter never wraps.

A four-bit control word sets the interval, a run bit and a lock bit. While unlocked, software may start and stop the watchdog freely. Once the lock bit is written, the watchdog runs regardless of the run bit and the whole control word is frozen. Only a system reset releases it: either the external asynchronous reset or the block's own overflow, which clears the control word as its reset pulse begins. After power-on the watchdog is idle until software enables it.

Top module: `wdog_lockable`

## Requirements
- R1: After `rst_n` is released, `cfg_rdata` reads 0, `wd_rst` is low, and edges on any tap are ignored.
- R2: The control word is laid out as bit 3 = lock, bit 2 = run, bits 1:0 = interval code. While unlocked, a `cfg_wr` strobe loads it, and `cfg_rdata` returns the stored value one cycle later.
- R3: Interval code 3 counts rising edges of `tap_i[0]`, code 2 those of `tap_i[1]`, code 1 those of `tap_i[2]`, and code 0 counts every eighth rising edge of `tap_i[2]`. Edges on the taps that are not selected have no effect.
- R4: The overflow counter is 3 bits wide. The eighth counted tick after a clear or an enable overflows it, and `wd_rst` rises in the cycle after the clock edge that took that tick.
- R5: Each overflow holds `wd_rst` high for exactly 4 consecutive clock cycles.
- R6: A `clr_rd` strobe zeroes the overflow counter and the divide-by-eight stage. If a tick arrives in the same cycle, the clear wins and the count ends at zero, so no overflow occurs in that cycle.
- R7: While run is 0 (and lock is 0), the counter and divider are held at zero and ticks are ignored.
- R8: Writing lock = 1 also sets run = 1. While lock is 1, every `cfg_wr` is ignored and the watchdog keeps counting.
- R9: An overflow clears the control word to 0 one cycle after `wd_rst` rises, and this releases the lock. Asserting `rst_n` also clears a locked control word at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tap_i | input | 3 | Prescaler tap levels: [0] fine, [1] mid, [2] coarse |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word write data |
| cfg_rdata | output | 4 | Current control word |
| clr_rd | input | 1 | Clear-read strobe, restarts the count |
| wd_rst | output | 1 | Watchdog reset pulse, high for 4 cycles |

## Verification
The hardest situation to reach is a clear read that lands in exactly the cycle in which the counter already holds seven and a selected tap edge arrives. The bench builds up seven ticks on the fine tap and then raises the clear strobe and the tap level at the same negative clock edge. It then counts how many further ticks are needed before the pulse appears, which shows that the counter ended at zero. The long interval is reached in the same way: the bench sweeps all four codes and drives sixty-four coarse edges, so the divider wrap and the counter wrap happen on the same edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // interval codes; code value order matters: it is the control field encoding
   typedef enum logic [1:0] {
      IV_DIV8   = 2'd0,
      IV_COARSE = 2'd1,
      IV_MID    = 2'd2,
      IV_FINE   = 2'd3
   } iv_code_e;

   localparam int CFG_W    = 4;
   localparam int LOCK_BIT = 3;
   localparam int RUN_BIT  = 2;

   typedef struct packed {
      logic     lock;
      logic     run;
      iv_code_e iv;
   } wd_cfg_t;

endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel
   import wdog_pkg::*;
#(
   parameter int NUM_TAPS = 3,
   parameter int DIV_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                clr,
   input  iv_code_e            sel,
   input  logic [NUM_TAPS-1:0] taps,
   output logic                tick
);

   localparam int TAP_FINE   = 0;
   localparam int TAP_MID    = 1;
   localparam int TAP_COARSE = NUM_TAPS - 1;

   if (NUM_TAPS != 3) begin : g_chk_taps
      $error("wdog_tick_sel: NUM_TAPS must be 3");
   end
   if (DIV_W < 0) begin : g_chk_div
      $error("wdog_tick_sel: DIV_W must not be negative");
   end

   logic [NUM_TAPS-1:0] rise;
   logic                slow_tick;
   logic                tick_raw;

   // one rising-edge detector per tap
   for (genvar g = 0; g < NUM_TAPS; g++) begin : g_edge
      logic tap_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tap_d <= 1'b0;
         else        tap_d <= taps[g];
      end
      assign rise[g] = taps[g] & ~tap_d;
   end

   // optional extra divider behind the coarse tap
   if (DIV_W > 0) begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  div_q <= '0;
         else if (!en || clr)         div_q <= '0;
         else if (rise[TAP_COARSE])   div_q <= div_q + 1'b1;
      end
      assign slow_tick = rise[TAP_COARSE] & (&div_q);

      AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (!en || clr) |=> div_q == '0) else $error("divider not held"); // R7
   end else begin : g_nodiv
      assign slow_tick = rise[TAP_COARSE];
   end

   always_comb begin
      case (sel)
         IV_FINE:   tick_raw = rise[TAP_FINE];
         IV_MID:    tick_raw = rise[TAP_MID];
         IV_COARSE: tick_raw = rise[TAP_COARSE];
         IV_DIV8:   tick_raw = slow_tick;
         default:   tick_raw = 1'b0;
      endcase
   end

   assign tick = en & tick_raw;

   AST_FINE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sel == IV_FINE && tick) |-> $rose(taps[TAP_FINE]))
      else $error("fine tick without tap edge"); // R3

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] wdata,
   input  logic             sys_clr,
   output wd_cfg_t          cfg
);

   wd_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (sys_clr) begin
         cfg_q <= '0;
      end else if (wr && !cfg_q.lock) begin
         cfg_q.lock <= wdata[LOCK_BIT];
         cfg_q.run  <= wdata[RUN_BIT] | wdata[LOCK_BIT];
         cfg_q.iv   <= iv_code_e'(wdata[1:0]);
      end
   end

   assign cfg = cfg_q;

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.lock && !sys_clr) |=> (cfg_q.lock && cfg_q.run))
      else $error("lock released by software"); // R8
   AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.lock && !sys_clr) |=> $stable(cfg_q))
      else $error("locked word changed"); // R8
   AST_SYSCLR_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
      sys_clr |=> (cfg_q == '0))
      else $error("overflow left control set"); // R9

endmodule

// File: rtl/wdog_ovf_core.sv
module wdog_ovf_core #(
   parameter int CNT_W     = 3,
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic tick,
   output logic wd_rst
);

   localparam int PULSE_W = $clog2(PULSE_LEN + 1);
   localparam int HI_W    = $clog2(PULSE_LEN + 2);

   if (CNT_W < 1) begin : g_chk_cnt
      $error("wdog_ovf_core: CNT_W must be at least 1");
   end
   if (PULSE_LEN < 1) begin : g_chk_pulse
      $error("wdog_ovf_core: PULSE_LEN must be at least 1");
   end

   logic [CNT_W-1:0]   cnt_q;
   logic [PULSE_W-1:0] pulse_q;
   logic               ovf;

   assign ovf = en & tick & ~clr & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (!en || clr || ovf)   cnt_q <= '0;
      else if (tick)                cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pulse_q <= '0;
      else if (ovf)           pulse_q <= PULSE_W'(PULSE_LEN);
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
   end

   assign wd_rst = (pulse_q != '0);

   // length of the current high run, for the pulse checks
   logic [HI_W-1:0] hi_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_len_q <= '0;
      else if (wd_rst) hi_len_q <= hi_len_q + 1'b1;
      else             hi_len_q <= '0;
   end

   AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0) else $error("clear did not zero count"); // R6
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> cnt_q == '0) else $error("count moved while idle"); // R7
   AST_OVF_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !clr && (&cnt_q)) |=> wd_rst)
      else $error("overflow did not fire"); // R4
   AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |-> (hi_len_q < HI_W'(PULSE_LEN)))
      else $error("pulse too long"); // R5
   AST_PULSE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_rst) |-> (hi_len_q == HI_W'(PULSE_LEN)))
      else $error("pulse too short"); // R5

endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
   import wdog_pkg::*;
#(
   parameter int NUM_TAPS  = 3,
   parameter int DIV_W     = 3,
   parameter int CNT_W     = 3,
   parameter int PULSE_LEN = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TAPS-1:0] tap_i,
   input  logic                cfg_wr,
   input  logic [CFG_W-1:0]    cfg_wdata,
   output logic [CFG_W-1:0]    cfg_rdata,
   input  logic                clr_rd,
   output logic                wd_rst
);

   wd_cfg_t cfg;
   logic    active;
   logic    tick;

   wdog_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (cfg_wr),
      .wdata   (cfg_wdata),
      .sys_clr (wd_rst),
      .cfg     (cfg)
   );

   // counting stops while the reset pulse is out
   assign active = cfg.run & ~wd_rst;

   wdog_tick_sel #(
      .NUM_TAPS (NUM_TAPS),
      .DIV_W    (DIV_W)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (active),
      .clr   (clr_rd),
      .sel   (cfg.iv),
      .taps  (tap_i),
      .tick  (tick)
   );

   wdog_ovf_core #(
      .CNT_W     (CNT_W),
      .PULSE_LEN (PULSE_LEN)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (active),
      .clr    (clr_rd),
      .tick   (tick),
      .wd_rst (wd_rst)
   );

   assign cfg_rdata = cfg;

endmodule

// File: tb/wdog_lockable_test.sv
`timescale 1ns/1ps
module wdog_lockable_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] tap_i = '0;
   logic       cfg_wr = 1'b0;
   logic [3:0] cfg_wdata = '0;
   logic [3:0] cfg_rdata;
   logic       clr_rd = 1'b0;
   logic       wd_rst;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wdog_lockable uut (
      .clk (clk), .rst_n (rst_n), .tap_i (tap_i), .cfg_wr (cfg_wr),
      .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .clr_rd (clr_rd),
      .wd_rst (wd_rst)
   );

   // bench-side pulse monitor
   int  n_rises = 0;
   int  run_len = 0;
   int  last_len = 0;
   bit  prev_rst = 1'b0;
   always @(negedge clk) begin
      if (wd_rst) begin
         if (!prev_rst) n_rises++;
         run_len++;
      end else if (prev_rst) begin
         last_len = run_len;
         run_len = 0;
      end
      prev_rst = wd_rst;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [3:0] d);
      cfg_wr = 1'b1; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic clear();
      clr_rd = 1'b1;
      @(negedge clk);
      clr_rd = 1'b0;
   endtask

   task automatic tick(input int idx);
      tap_i[idx] = 1'b1;
      @(negedge clk);
      tap_i[idx] = 1'b0;
      @(negedge clk);
   endtask

   task automatic ticks(input int idx, input int n);
      for (int i = 0; i < n; i++) tick(idx);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   initial begin
      int base;
      int idx;
      int per;
      int other;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state, ticks ignored
      check("R1 cfg after reset", cfg_rdata, 0);
      check("R1 wd_rst after reset", wd_rst, 0);
      base = n_rises;
      for (int t = 0; t < 3; t++) ticks(t, 10);
      check("R1 idle ticks ignored", n_rises - base, 0);

      // R2/R3/R4/R5/R9: sweep over all interval codes
      for (int c = 0; c < 4; c++) begin
         idx   = (c == 3) ? 0 : (c == 2) ? 1 : 2;
         per   = (c == 0) ? 8 : 1;
         other = (idx == 0) ? 1 : 0;
         write_cfg(4'(4 + c));
         check("R2 cfg readback", cfg_rdata, 4 + c);
         clear();
         base = n_rises;
         for (int k = 1; k <= 8; k++) begin
            ticks(other, 2);
            ticks(idx, per);
            check($sformatf("R3/R4 code %0d tick %0d", c, k),
                  n_rises - base, (k == 8) ? 1 : 0);
         end
         settle();
         check($sformatf("R5 pulse length code %0d", c), last_len, 4);
         check($sformatf("R9 cfg cleared code %0d", c), cfg_rdata, 0);
      end

      // R6: plain clear
      write_cfg(4'h7);
      clear();
      base = n_rises;
      ticks(0, 6);
      clear();
      ticks(0, 7);
      check("R6 clear restarts count", n_rises - base, 0);
      tick(0);
      check("R6 eighth tick after clear", n_rises - base, 1);
      settle();

      // R6: clear coinciding with a tick at count seven
      write_cfg(4'h7);
      clear();
      base = n_rises;
      ticks(0, 7);
      tap_i[0] = 1'b1; clr_rd = 1'b1;
      @(negedge clk);
      tap_i[0] = 1'b0; clr_rd = 1'b0;
      @(negedge clk);
      check("R6 clear beats tick", n_rises - base, 0);
      ticks(0, 7);
      check("R6 count ended at zero", n_rises - base, 0);
      tick(0);
      check("R6 fires after eight more", n_rises - base, 1);
      settle();

      // R7: run off holds the counter at zero
      write_cfg(4'h7);
      clear();
      base = n_rises;
      ticks(0, 5);
      write_cfg(4'h3);
      check("R7 run cleared", cfg_rdata, 3);
      ticks(0, 12);
      check("R7 ticks ignored while off", n_rises - base, 0);
      write_cfg(4'h7);
      ticks(0, 7);
      check("R7 count held at zero", n_rises - base, 0);
      tick(0);
      check("R7 fires after re-enable", n_rises - base, 1);
      settle();

      // R8: lock forces run and freezes the word
      write_cfg(4'hB);
      check("R8 lock forces run", cfg_rdata, 15);
      clear();
      write_cfg(4'h0);
      check("R8 write of zero ignored", cfg_rdata, 15);
      write_cfg(4'h5);
      check("R8 interval write ignored", cfg_rdata, 15);
      base = n_rises;
      ticks(0, 7);
      check("R8 no early fire", n_rises - base, 0);
      tick(0);
      check("R8 locked watchdog fires", n_rises - base, 1);
      settle();
      check("R9 overflow releases lock", cfg_rdata, 0);
      write_cfg(4'h5);
      check("R9 writable after release", cfg_rdata, 5);

      // R9: asynchronous reset releases lock
      write_cfg(4'h8);
      check("R8 lock set again", cfg_rdata, 12);
      rst_n = 1'b0;
      #1;
      check("R9 reset clears locked word", cfg_rdata, 0);
      check("R9 reset keeps wd_rst low", wd_rst, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL all watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule